// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a program sequencer and turns a single loop instruction into a hardware-repeated block of code. In every cycle the sequencer presents the instruction word it is executing and that word's address. The controller decodes the loop opcode, keeps the start address, end address and remaining pass count of the most recent loop, and asks the sequencer to jump back to the loop start whenever the last body instruction of a non-final pass executes. No branch instruction is spent on the loop.

One opcode covers two flavours. The instruction-count field (bits 10..7) tells them apart. A non-zero count opens a new loop over the instructions that follow it. A zero count replays the loop already stored, with a new pass count, and then continues at the instruction after the replay instruction once the final pass ends. The controller drives only a next-PC override and a flag that marks the extra cycle a replay takes. Fetch, instruction storage and every other opcode belong to the sequencer.

Top module: `zloop_ctrl`

## Requirements
- R1: After reset the stored start address, end address and pass count are all zero and no resume address is pending. An ordinary instruction at address 0xFFFF (whose successor equals the reset end address 0) therefore gives no override.
- R2: A loop word is bits 15..11 = 0x0E, with the instruction count NI in bits 10..7 and the pass count K in bits 6..0. When NI is non-zero the word opens a loop: its start becomes PC+1 and its end becomes PC+NI+1 (modulo 2^16). The word raises neither the override nor the extra-cycle flag.
- R3: When an ordinary instruction executes at address end−1 and the remaining count is above zero, the override jumps to the loop start and the count drops by one. A body therefore runs K times in total, for K from 1 to 127.
- R4: K of 0 or 1 gives a remaining count of zero. The body runs once, and no override occurs at its end.
- R5: A loop word with NI equal to zero (a replay) raises the override to the stored loop start and raises the extra-cycle flag in the same cycle. It loads a remaining count of K−1 (zero for K of 0).
- R6: After a replay, when the final pass reaches its end, the override jumps to the replay's address plus one. The pending resume is then cleared, so later passes through the loop end give no override.
- R7: A replay issued before any loop has been opened jumps to address 0.
- R8: In a cycle where the execute-valid input is low, no override is raised and nothing is stored, even if the word is a loop word.
- R9: A word whose bits 15..11 differ from 0x0E is treated as an ordinary instruction, whatever its other bits hold.
- R10: Opening a new loop cancels any pending resume address from an earlier replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_vld | input | 1 | An instruction is executing this cycle |
| exec_word | input | 16 | Instruction word being executed |
| exec_pc | input | PC_W | Address of the executing word |
| ovr_vld | output | 1 | Sequencer must take ovr_pc as next PC |
| ovr_pc | output | PC_W | Next-PC override (PC+1 when ovr_vld is low) |
| extra_cyc | output | 1 | The executing replay word needs a second cycle |

## Verification
A wrong stored start address shows up at the very next repeat or replay, as an override target that differs from the address after the opening word. A wrong end address moves the jump to the wrong body instruction, so it appears on the first pass. A count that is off by one, or one that wraps at zero, changes how many passes are seen before the loop falls through. That can only be seen at the end of the final pass, so long loops (K=127) and short ones (K of 0 and 1) are both run. A resume flag left set is hidden until the loop end is crossed again, so the bench crosses it once more after every replay.

// File: rtl/zloop_pkg.sv
package zloop_pkg;

    localparam int unsigned ZL_WORD_W = 16;
    localparam int unsigned ZL_OPC_W  = 5;
    localparam int unsigned ZL_NI_W   = 4;
    localparam int unsigned ZL_K_W    = 7;

    localparam int unsigned ZL_OPC_LSB = ZL_NI_W + ZL_K_W;
    localparam int unsigned ZL_NI_LSB  = ZL_K_W;

    localparam logic [ZL_OPC_W-1:0] ZL_LOOP_OPC = 5'h0e;

    typedef struct packed {
        logic              is_open;
        logic              is_replay;
        logic [ZL_NI_W-1:0] ni;
        logic [ZL_K_W-1:0]  rem;
    } zl_dec_t;

    typedef enum logic [1:0] {
        ZL_ACT_NONE,
        ZL_ACT_REPEAT,
        ZL_ACT_RESUME,
        ZL_ACT_REPLAY
    } zl_act_e;

endpackage

// File: rtl/zloop_decode.sv
module zloop_decode
    import zloop_pkg::*;
(
    input  logic                 vld,
    input  logic [ZL_WORD_W-1:0] word,
    output zl_dec_t              dec
);

    logic [ZL_OPC_W-1:0] opc_w;
    logic [ZL_NI_W-1:0]  ni_w;
    logic [ZL_K_W-1:0]   k_w;
    logic                hit_w;

    always_comb begin
        opc_w = word[ZL_OPC_LSB +: ZL_OPC_W];
        ni_w  = word[ZL_NI_LSB +: ZL_NI_W];
        k_w   = word[0 +: ZL_K_W];
        hit_w = vld && (opc_w == ZL_LOOP_OPC);

        dec.is_open   = hit_w && (ni_w != '0);
        dec.is_replay = hit_w && (ni_w == '0);
        dec.ni        = ni_w;
        // saturate at zero: K of 0 behaves as K of 1
        dec.rem       = (k_w == '0) ? '0 : (k_w - ZL_K_W'(1));
    end

endmodule

// File: rtl/zloop_addr.sv
module zloop_addr
    import zloop_pkg::*;
#(
    parameter int unsigned PC_W = 16
) (
    input  logic [PC_W-1:0]    pc,
    input  logic [ZL_NI_W-1:0] ni,
    input  logic [PC_W-1:0]    stop_q,
    output logic [PC_W-1:0]    pc_inc,
    output logic [PC_W-1:0]    stop_new,
    output logic               at_stop
);

    always_comb begin
        pc_inc   = pc + PC_W'(1);
        stop_new = pc_inc + PC_W'(ni);
        at_stop  = (pc_inc == stop_q);
    end

endmodule

// File: rtl/zloop_ctrl.sv
module zloop_ctrl
    import zloop_pkg::*;
#(
    parameter int unsigned PC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exec_vld,
    input  logic [ZL_WORD_W-1:0] exec_word,
    input  logic [PC_W-1:0]      exec_pc,
    output logic                 ovr_vld,
    output logic [PC_W-1:0]      ovr_pc,
    output logic                 extra_cyc
);

    typedef struct packed {
        logic [PC_W-1:0]   start;
        logic [PC_W-1:0]   stop;
        logic [ZL_K_W-1:0] cnt;
        logic [PC_W-1:0]   resume;
        logic              resume_vld;
    } zl_state_t;

    zl_state_t st_d, st_q;
    zl_dec_t   dec_w;
    zl_act_e   act_d;
    logic [PC_W-1:0] pc_inc_w;
    logic [PC_W-1:0] stop_new_w;
    logic            at_stop_w;

    zloop_decode u_dec (
        .vld  (exec_vld),
        .word (exec_word),
        .dec  (dec_w)
    );

    zloop_addr #(.PC_W(PC_W)) u_addr (
        .pc       (exec_pc),
        .ni       (dec_w.ni),
        .stop_q   (st_q.stop),
        .pc_inc   (pc_inc_w),
        .stop_new (stop_new_w),
        .at_stop  (at_stop_w)
    );

    always_comb begin
        st_d  = st_q;
        act_d = ZL_ACT_NONE;
        if (exec_vld) begin
            if (dec_w.is_open) begin
                st_d.start      = pc_inc_w;
                st_d.stop       = stop_new_w;
                st_d.cnt        = dec_w.rem;
                st_d.resume_vld = 1'b0;
            end else if (dec_w.is_replay) begin
                act_d           = ZL_ACT_REPLAY;
                st_d.cnt        = dec_w.rem;
                st_d.resume     = pc_inc_w;
                st_d.resume_vld = 1'b1;
            end else if (at_stop_w) begin
                if (st_q.cnt != '0) begin
                    act_d    = ZL_ACT_REPEAT;
                    st_d.cnt = st_q.cnt - ZL_K_W'(1);
                end else if (st_q.resume_vld) begin
                    act_d           = ZL_ACT_RESUME;
                    st_d.resume_vld = 1'b0;
                end
            end
        end

        unique case (act_d)
            ZL_ACT_REPEAT, ZL_ACT_REPLAY: ovr_pc = st_q.start;
            ZL_ACT_RESUME:                ovr_pc = st_q.resume;
            default:                      ovr_pc = pc_inc_w;
        endcase
        ovr_vld   = (act_d != ZL_ACT_NONE);
        extra_cyc = (act_d == ZL_ACT_REPLAY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/zloop_ctrl_chk.sv
module zloop_ctrl_chk
    import zloop_pkg::*;
#(
    parameter int unsigned PC_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 exec_vld,
    input logic [ZL_WORD_W-1:0] exec_word,
    input logic [PC_W-1:0]      exec_pc,
    input logic                 ovr_vld,
    input logic [PC_W-1:0]      ovr_pc,
    input logic                 extra_cyc
);

    logic            loop_w, open_w, replay_w;
    logic [PC_W-1:0] shadow_start, shadow_stop;

    assign loop_w   = exec_vld && (exec_word[ZL_OPC_LSB +: ZL_OPC_W] == ZL_LOOP_OPC);
    assign open_w   = loop_w && (exec_word[ZL_NI_LSB +: ZL_NI_W] != '0);
    assign replay_w = loop_w && (exec_word[ZL_NI_LSB +: ZL_NI_W] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_start <= '0;
            shadow_stop  <= '0;
        end else if (open_w) begin
            shadow_start <= exec_pc + PC_W'(1);
            shadow_stop  <= exec_pc + PC_W'(1) + PC_W'(exec_word[ZL_NI_LSB +: ZL_NI_W]);
        end
    end

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_vld |-> !ovr_vld && !extra_cyc);

    // R2
    open_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_w |-> !ovr_vld && !extra_cyc);

    // R5
    replay_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_w |-> ovr_vld && extra_cyc && (ovr_pc == shadow_start));

    // R5
    extra_only_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        extra_cyc |-> replay_w);

    // R3
    jump_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_vld && !extra_cyc |-> ((exec_pc + PC_W'(1)) == shadow_stop));

endmodule

bind zloop_ctrl zloop_ctrl_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_vld  (exec_vld),
    .exec_word (exec_word),
    .exec_pc   (exec_pc),
    .ovr_vld   (ovr_vld),
    .ovr_pc    (ovr_pc),
    .extra_cyc (extra_cyc)
);

// File: tb/zloop_ctrl_test.sv
module zloop_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_vld = 1'b0;
    logic [15:0] exec_word = '0;
    logic [15:0] exec_pc = '0;
    logic        ovr_vld;
    logic [15:0] ovr_pc;
    logic        extra_cyc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic        ev;
        logic [15:0] ep;
        logic        ex;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    localparam logic [15:0] NOP = 16'h0000;

    always #2 clk = ~clk;

    zloop_ctrl #(.PC_W(16)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_vld  (exec_vld),
        .exec_word (exec_word),
        .exec_pc   (exec_pc),
        .ovr_vld   (ovr_vld),
        .ovr_pc    (ovr_pc),
        .extra_cyc (extra_cyc)
    );

    function automatic logic [15:0] lp(input int ni, input int k);
        return {5'h0e, 4'(ni), 7'(k)};
    endfunction

    task automatic step(input logic v, input logic [15:0] w, input logic [15:0] p,
                        input logic ev, input logic [15:0] ep, input logic ex,
                        input string req);
        exp_t e;
        @(negedge clk);
        exec_vld  = v;
        exec_word = w;
        exec_pc   = p;
        e.ev = ev; e.ep = ep; e.ex = ex; e.req = req;
        exp_q.push_back(e);
    endtask

    // walk a loop body for a number of passes; jump expected on each pass end
    task automatic run_body(input logic [15:0] start, input int ni, input int passes,
                            input logic [15:0] resume, input logic has_res,
                            input string req);
        for (int p = 0; p < passes; p++) begin
            for (int i = 0; i < ni; i++) begin
                logic [15:0] a;
                a = start + 16'(i);
                if (i == ni - 1 && p < passes - 1)
                    step(1'b1, NOP, a, 1'b1, start, 1'b0, req);
                else if (i == ni - 1 && has_res)
                    step(1'b1, NOP, a, 1'b1, resume, 1'b0, req);
                else
                    step(1'b1, NOP, a, 1'b0, 16'h0, 1'b0, req);
            end
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (ovr_vld !== e.ev || extra_cyc !== e.ex || (e.ev && ovr_pc !== e.ep)) begin
                    bad++;
                    $display("FAIL %s: got vld=%b pc=%h extra=%b, expected vld=%b pc=%h extra=%b",
                             e.req, ovr_vld, ovr_pc, extra_cyc, e.ev, e.ep, e.ex);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        step(1'b0, NOP, 16'h0000, 1'b0, 16'h0, 1'b0, "R8");
        step(1'b1, NOP, 16'hffff, 1'b0, 16'h0, 1'b0, "R1");
        step(1'b1, lp(0, 1), 16'h0100, 1'b1, 16'h0000, 1'b1, "R7");

        // open loop at 0x10: body 0x11..0x13, four passes
        step(1'b1, lp(3, 4), 16'h0010, 1'b0, 16'h0, 1'b0, "R2");
        run_body(16'h0011, 3, 4, 16'h0, 1'b0, "R3");
        step(1'b1, NOP, 16'h0014, 1'b0, 16'h0, 1'b0, "R3");
        step(1'b0, NOP, 16'h0013, 1'b0, 16'h0, 1'b0, "R8");

        // replay from 0x20, two passes then resume at 0x21
        step(1'b1, lp(0, 2), 16'h0020, 1'b1, 16'h0011, 1'b1, "R5");
        run_body(16'h0011, 3, 2, 16'h0021, 1'b1, "R6");
        step(1'b1, NOP, 16'h0021, 1'b0, 16'h0, 1'b0, "R6");
        step(1'b1, NOP, 16'h0013, 1'b0, 16'h0, 1'b0, "R6");

        // K of 0 and 1: single pass
        step(1'b1, lp(2, 0), 16'h0040, 1'b0, 16'h0, 1'b0, "R4");
        run_body(16'h0041, 2, 1, 16'h0, 1'b0, "R4");
        step(1'b1, lp(2, 1), 16'h0040, 1'b0, 16'h0, 1'b0, "R4");
        run_body(16'h0041, 2, 1, 16'h0, 1'b0, "R4");

        // replay K=0 leaves a resume pending; a new loop drops it
        step(1'b1, lp(0, 0), 16'h0050, 1'b1, 16'h0041, 1'b1, "R5");
        step(1'b1, lp(1, 2), 16'h0060, 1'b0, 16'h0, 1'b0, "R10");
        run_body(16'h0061, 1, 2, 16'h0, 1'b0, "R10");

        // loop word with valid low is ignored
        step(1'b1, lp(2, 3), 16'h0070, 1'b0, 16'h0, 1'b0, "R2");
        step(1'b0, lp(0, 5), 16'h0072, 1'b0, 16'h0, 1'b0, "R8");
        run_body(16'h0071, 2, 3, 16'h0, 1'b0, "R8");

        // other opcodes are ordinary instructions
        step(1'b1, lp(2, 2), 16'h0080, 1'b0, 16'h0, 1'b0, "R2");
        step(1'b1, 16'h7f85, 16'h0081, 1'b0, 16'h0, 1'b0, "R9");
        step(1'b1, 16'h7800, 16'h0082, 1'b1, 16'h0081, 1'b0, "R9");
        run_body(16'h0081, 2, 1, 16'h0, 1'b0, "R9");

        // address wrap with the widest body
        step(1'b1, lp(15, 2), 16'hfff8, 1'b0, 16'h0, 1'b0, "R2");
        run_body(16'hfff9, 15, 2, 16'h0, 1'b0, "R2");

        // largest pass count
        step(1'b1, lp(1, 127), 16'h0090, 1'b0, 16'h0, 1'b0, "R3");
        run_body(16'h0091, 1, 127, 16'h0, 1'b0, "R3");
        step(1'b1, NOP, 16'h0091, 1'b0, 16'h0, 1'b0, "R3");

        @(negedge clk);
        exec_vld = 1'b0;
        wait (exp_q.size() == 0);
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule